// File: doc/BRIEF.md
# Serial Bit-Clock and Frame-Sync Generator

This block supplies a synchronous serial port with its bit clock and frame-sync pulse. A selectable source (every system clock cycle, or each rising edge of an external clock pin) is divided by a programmable ratio of (divider + 1). The result is a generated clock, plus a one-cycle strobe that marks each of its rising edges. A frame-sync former counts these strobes. It either emits a pulse of programmable width at a programmable period, or emits one pulse at the first generated-clock edge after the port copies a word from its transmit buffer into its shift register.

Everything runs in the system clock domain. The external clock pin is synchronised and edge-detected, so its frequency must stay well below the system clock. Direction bits choose what the port sees. Each generated signal can drive its pin, and the port then uses it. Or the pin is left undriven and the port uses the level sampled on that pin. The divider and the frame-sync former each have their own active-low reset, so they can be held and released one at a time.

Top module: `sfg_top`

## Requirements
- R1: With the internal source and divider value D ≥ 1, `clk_pin_out` rises every D+1 system clock cycles.
- R2: With ratio N = D+1, the generated clock is high for ceil(N/2) source ticks and low for floor(N/2) ticks. With D = 0 it stays high.
- R3: With the external source (`src_sel` = 1), one tick occurs per rising edge of `ext_clk`. The generated clock period is therefore (D+1) external periods and its high phase is ceil(N/2) external periods.
- R4: While `div_rst_n` is low, `clk_pin_out` is 0 from the next system edge onward. The first system edge after release with a tick drives it high.
- R5: With `frame_mode` = 1, `fs_pin_out` rises every (P+1) generated-clock periods for period field P, and stays high for (W+1) periods for width field W < P. Each rise comes one system cycle after a generated-clock rising edge.
- R6: With `frame_mode` = 0, no frame sync occurs without a load. A one-cycle `xfer_load` causes a single pulse that starts one system cycle after the next generated-clock rising edge and lasts (W+1) periods.
- R7: With `frame_mode` = 0, a load sampled in the same cycle as the rising-edge strobe starts the pulse on that edge. A load during an active pulse restarts the width count at the following edge.
- R8: While `fs_rst_n` is low, `fs_pin_out` is 0 from the next edge and loads are discarded. After release in periodic mode, the first generated-clock edge starts a frame.
- R9: `clk_pin_oe` follows `clk_dir` and `fs_pin_oe` follows `fs_dir`, where 1 means output. With dir = 1 the port signal (`bit_clk` / `frame_sync`) is the generated one. With dir = 0 it is the pin input.
- R10: `rst_n` low clears the generated clock and frame sync at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_rst_n | input | 1 | Divider reset, active low |
| fs_rst_n | input | 1 | Frame-sync former reset, active low |
| src_sel | input | 1 | 0 = system clock, 1 = external clock pin |
| ext_clk | input | 1 | External clock source pin |
| div | input | 8 | Divider value D, ratio D+1 |
| frame_mode | input | 1 | 0 = sync on transmit load, 1 = periodic |
| per | input | 12 | Frame period field P |
| wid | input | 8 | Pulse width field W |
| xfer_load | input | 1 | One-cycle strobe: transmit buffer copied to shift register |
| clk_dir | input | 1 | Clock pin direction, 1 = output |
| fs_dir | input | 1 | Frame-sync pin direction, 1 = output |
| clk_pin_in | input | 1 | Level sampled on the clock pin |
| fs_pin_in | input | 1 | Level sampled on the frame-sync pin |
| clk_pin_out | output | 1 | Generated clock to the pin |
| clk_pin_oe | output | 1 | Clock pin output enable |
| fs_pin_out | output | 1 | Generated frame sync to the pin |
| fs_pin_oe | output | 1 | Frame-sync pin output enable |
| bit_clk | output | 1 | Bit clock used by the port |
| frame_sync | output | 1 | Frame sync used by the port |

## Verification
Two events can share a cycle: a transmit load arriving and the rising-edge strobe that consumes pending loads. The bench waits for a generated-clock rise, then drives `xfer_load` so that it is sampled together with the strobe. It requires the frame sync to rise on that very edge and not one generated period later. A second case places a load inside a pulse that is already running. The pulse must then stretch to end (W+1) periods after the next edge, with no falling edge in between.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  typedef enum logic {SRC_INTERNAL = 1'b0, SRC_EXTERNAL = 1'b1} src_e;
  typedef enum logic {FS_ON_LOAD = 1'b0, FS_PERIODIC = 1'b1} fmode_e;
endpackage

// File: rtl/sfg_src_tick.sv
module sfg_src_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic src_sel,
  output logic src_tick
);
  import sfg_pkg::*;

  logic [SYNC_STAGES:0] sync_q;
  logic [SYNC_STAGES:0] sync_d;
  logic                 ext_rise;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-1:0], ext_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign src_tick = (src_sel == SRC_EXTERNAL) ? ext_rise : 1'b1;

  // R3: an external tick is a single-cycle pulse
  assert_ext_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);
endmodule

// File: rtl/sfg_divider.sv
module sfg_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_rst_n,
  input  logic             src_tick,
  input  logic [DIV_W-1:0] div,
  output logic             gen_clk,
  output logic             rise_stb
);
  localparam int HI_W = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             clk_q, clk_d;
  logic             stb_q, stb_d;
  logic [HI_W-1:0]  hi_len;
  logic             wrap;

  assign hi_len = ({1'b0, div} + HI_W'(2)) >> 1;

  always_comb begin
    cnt_d = cnt_q;
    clk_d = clk_q;
    stb_d = 1'b0;
    wrap  = (cnt_q >= div);
    if (!div_rst_n) begin
      cnt_d = div;
      clk_d = 1'b0;
    end else if (src_tick) begin
      cnt_d = wrap ? '0 : cnt_q + DIV_W'(1);
      clk_d = ({1'b0, cnt_d} < hi_len);
      stb_d = wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= clk_d;
      stb_q <= stb_d;
    end
  end

  assign gen_clk  = clk_q;
  assign rise_stb = stb_q;

  assert_div_reset_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !div_rst_n |=> !gen_clk);
  assert_rise_has_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_clk) |-> rise_stb);
  assert_no_strobe_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !div_rst_n |=> !rise_stb);
endmodule

// File: rtl/sfg_fs_former.sv
module sfg_fs_former #(
  parameter int PER_W = 12,
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_rst_n,
  input  logic             rise_stb,
  input  logic             frame_mode,
  input  logic [PER_W-1:0] per,
  input  logic [WID_W-1:0] wid,
  input  logic             xfer_load,
  output logic             fs
);
  import sfg_pkg::*;

  logic [PER_W-1:0] pcnt_q, pcnt_d;
  logic [WID_W-1:0] wcnt_q, wcnt_d;
  logic             fs_q, fs_d;
  logic             pend_q, pend_d;
  logic             load_now, pwrap, start;

  always_comb begin
    pcnt_d   = pcnt_q;
    wcnt_d   = wcnt_q;
    fs_d     = fs_q;
    pend_d   = pend_q;
    load_now = xfer_load && (frame_mode == FS_ON_LOAD);
    pwrap    = (pcnt_q >= per);
    start    = 1'b0;
    if (!fs_rst_n) begin
      pcnt_d = per;
      wcnt_d = '0;
      fs_d   = 1'b0;
      pend_d = 1'b0;
    end else if (rise_stb) begin
      pcnt_d = pwrap ? '0 : pcnt_q + PER_W'(1);
      start  = (frame_mode == FS_PERIODIC) ? pwrap : (pend_q | load_now);
      pend_d = 1'b0;
      if (start) begin
        fs_d   = 1'b1;
        wcnt_d = '0;
      end else if (fs_q) begin
        if (wcnt_q >= wid) fs_d = 1'b0;
        else               wcnt_d = wcnt_q + WID_W'(1);
      end
    end else if (load_now) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      wcnt_q <= '0;
      fs_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pcnt_q <= pcnt_d;
      wcnt_q <= wcnt_d;
      fs_q   <= fs_d;
      pend_q <= pend_d;
    end
  end

  assign fs = fs_q;

  assert_fs_reset_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_rst_n |=> !fs);
  assert_fs_only_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_rst_n && !rise_stb) |=> $stable(fs));
  assert_fs_rise_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs) |-> $past(rise_stb));
  assert_no_pending_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_rst_n |=> !pend_q);
endmodule

// File: rtl/sfg_top.sv
module sfg_top #(
  parameter int DIV_W       = 8,
  parameter int PER_W       = 12,
  parameter int WID_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_rst_n,
  input  logic             fs_rst_n,
  input  logic             src_sel,
  input  logic             ext_clk,
  input  logic [DIV_W-1:0] div,
  input  logic             frame_mode,
  input  logic [PER_W-1:0] per,
  input  logic [WID_W-1:0] wid,
  input  logic             xfer_load,
  input  logic             clk_dir,
  input  logic             fs_dir,
  input  logic             clk_pin_in,
  input  logic             fs_pin_in,
  output logic             clk_pin_out,
  output logic             clk_pin_oe,
  output logic             fs_pin_out,
  output logic             fs_pin_oe,
  output logic             bit_clk,
  output logic             frame_sync
);
  logic src_tick;
  logic gen_clk;
  logic rise_stb;
  logic gen_fs;

  sfg_src_tick #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .src_sel(src_sel),
    .src_tick(src_tick)
  );

  sfg_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div_rst_n(div_rst_n), .src_tick(src_tick),
    .div(div), .gen_clk(gen_clk), .rise_stb(rise_stb)
  );

  sfg_fs_former #(.PER_W(PER_W), .WID_W(WID_W)) u_fs (
    .clk(clk), .rst_n(rst_n), .fs_rst_n(fs_rst_n), .rise_stb(rise_stb),
    .frame_mode(frame_mode), .per(per), .wid(wid), .xfer_load(xfer_load),
    .fs(gen_fs)
  );

  assign clk_pin_out = gen_clk;
  assign clk_pin_oe  = clk_dir;
  assign fs_pin_out  = gen_fs;
  assign fs_pin_oe   = fs_dir;
  assign bit_clk     = clk_dir ? gen_clk : clk_pin_in;
  assign frame_sync  = fs_dir  ? gen_fs  : fs_pin_in;
endmodule

// File: tb/sfg_top_bench.sv
module sfg_top_bench;
  logic clk = 1'b0;
  logic rst_n, div_rst_n, fs_rst_n, src_sel, ext_clk;
  logic [7:0]  div;
  logic        frame_mode;
  logic [11:0] per;
  logic [7:0]  wid;
  logic xfer_load, clk_dir, fs_dir, clk_pin_in, fs_pin_in;
  logic clk_pin_out, clk_pin_oe, fs_pin_out, fs_pin_oe, bit_clk, frame_sync;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    ext_clk = 1'b0;
    #3;
    forever #32 ext_clk = ~ext_clk;
  end

  sfg_top u_sfg_top (
    .clk(clk), .rst_n(rst_n), .div_rst_n(div_rst_n), .fs_rst_n(fs_rst_n),
    .src_sel(src_sel), .ext_clk(ext_clk), .div(div), .frame_mode(frame_mode),
    .per(per), .wid(wid), .xfer_load(xfer_load), .clk_dir(clk_dir),
    .fs_dir(fs_dir), .clk_pin_in(clk_pin_in), .fs_pin_in(fs_pin_in),
    .clk_pin_out(clk_pin_out), .clk_pin_oe(clk_pin_oe), .fs_pin_out(fs_pin_out),
    .fs_pin_oe(fs_pin_oe), .bit_clk(bit_clk), .frame_sync(frame_sync)
  );

  // edge monitor, in system cycles
  logic g_prev = 1'b0, f_prev = 1'b0;
  int g_rise_t = 0, g_period = 0, g_high = 0, g_rise_n = 0;
  int f_rise_t = 0, f_period = 0, f_width = 0, f_gap = 0, f_rise_n = 0, f_fall_n = 0;

  always @(negedge clk) begin
    if (clk_pin_out && !g_prev) begin
      g_period = cyc - g_rise_t; g_rise_t = cyc; g_rise_n++;
    end
    if (!clk_pin_out && g_prev) g_high = cyc - g_rise_t;
    if (fs_pin_out && !f_prev) begin
      f_period = cyc - f_rise_t; f_rise_t = cyc; f_gap = cyc - g_rise_t; f_rise_n++;
    end
    if (!fs_pin_out && f_prev) begin
      f_width = cyc - f_rise_t; f_fall_n++;
    end
    g_prev = clk_pin_out;
    f_prev = fs_pin_out;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic setup(int d, bit s, bit m, int p, int w);
    div_rst_n = 1'b0; fs_rst_n = 1'b0;
    div = 8'(d); src_sel = s; frame_mode = m; per = 12'(p); wid = 8'(w);
    step(3);
    div_rst_n = 1'b1; fs_rst_n = 1'b1;
  endtask

  task automatic pulse_load();
    xfer_load = 1'b1; step(1); xfer_load = 1'b0;
  endtask

  task automatic t_reset();
    step(4);
    chk("R10 clk low in reset", clk_pin_out, 0);
    chk("R10 fs low in reset", fs_pin_out, 0);
    rst_n = 1'b1;
    setup(3, 0, 1, 4, 1);
    step(30);
    while (!clk_pin_out) step(1);
    rst_n = 1'b0;
    #1;
    chk("R10 async clear clk", clk_pin_out, 0);
    chk("R10 async clear fs", fs_pin_out, 0);
    step(1);
    rst_n = 1'b1;
  endtask

  task automatic t_div(int d);
    setup(d, 0, 1, 4, 0);
    step((d + 1) * 4 + 10);
    chk("R1 period", g_period, d + 1);
    chk("R2 high phase", g_high, (d + 2) / 2);
  endtask

  task automatic t_ext();
    setup(2, 1, 1, 4, 0);
    step(24 * 4 + 20);
    chk("R3 ext period", g_period, 24);
    chk("R3 ext high", g_high, 16);
  endtask

  task automatic t_divrst();
    setup(3, 0, 1, 4, 0);
    step(20);
    div_rst_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step(1);
      chk("R4 held low", clk_pin_out, 0);
    end
    div_rst_n = 1'b1;
    step(1);
    chk("R4 first edge", clk_pin_out, 1);
  endtask

  task automatic t_periodic(int d, int p, int w);
    setup(d, 0, 1, p, w);
    step(3 * (p + 1) * (d + 1) + 10);
    chk("R5 frame period", f_period, (p + 1) * (d + 1));
    chk("R5 frame width", f_width, (w + 1) * (d + 1));
    chk("R5 edge gap", f_gap, 1);
  endtask

  task automatic t_load();
    int n0, lt;
    setup(3, 0, 0, 9, 2);
    n0 = f_rise_n;
    step(100);
    chk("R6 no pulse without load", f_rise_n, n0);
    step(2);
    lt = cyc;
    pulse_load();
    step(30);
    chk("R6 one pulse", f_rise_n, n0 + 1);
    chk("R6 edge gap", f_gap, 1);
    chk("R6 width", f_width, 12);
    chk("R6 prompt start", int'(f_rise_t > lt && f_rise_t - lt <= 5), 1);
  endtask

  task automatic t_same();
    int gn, n;
    setup(3, 0, 0, 9, 1);
    step(10);
    gn = g_rise_n;
    while (g_rise_n == gn) step(1);
    n = cyc;
    pulse_load();
    step(20);
    chk("R7 same-cycle start", f_rise_t, n + 1);
  endtask

  task automatic t_restart();
    int fn, ff, t;
    setup(3, 0, 0, 9, 5);
    step(6);
    fn = f_rise_n;
    pulse_load();
    while (f_rise_n == fn) step(1);
    t = f_rise_t;
    ff = f_fall_n;
    step(4);
    pulse_load();
    step(60);
    chk("R7 single fall", f_fall_n, ff + 1);
    chk("R7 stretched width", f_width, 32);
    chk("R7 rise kept", f_rise_t, t);
  endtask

  task automatic t_fsrst();
    int fn;
    setup(3, 0, 1, 9, 2);
    fn = f_rise_n;
    while (f_rise_n == fn) step(1);
    step(1);
    fs_rst_n = 1'b0;
    step(1);
    chk("R8 fs cleared", fs_pin_out, 0);
    frame_mode = 1'b0;
    pulse_load();
    step(3);
    fn = f_rise_n;
    fs_rst_n = 1'b1;
    step(40);
    chk("R8 load dropped", f_rise_n, fn);
    fs_rst_n = 1'b0;
    frame_mode = 1'b1;
    step(2);
    fn = f_rise_n;
    fs_rst_n = 1'b1;
    step(10);
    chk("R8 first frame", f_rise_n, fn + 1);
    chk("R8 edge gap", f_gap, 1);
  endtask

  task automatic t_pins();
    int mism;
    setup(1, 0, 1, 3, 0);
    clk_dir = 1'b1; fs_dir = 1'b1;
    mism = 0;
    for (int i = 0; i < 16; i++) begin
      step(1);
      if (bit_clk !== clk_pin_out || frame_sync !== fs_pin_out) mism++;
    end
    chk("R9 output mode follows", mism, 0);
    chk("R9 clk oe", clk_pin_oe, 1);
    chk("R9 fs oe", fs_pin_oe, 1);
    clk_dir = 1'b0; fs_dir = 1'b0;
    clk_pin_in = 1'b1; fs_pin_in = 1'b0; #1;
    chk("R9 clk oe off", clk_pin_oe, 0);
    chk("R9 fs oe off", fs_pin_oe, 0);
    chk("R9 clk from pin hi", bit_clk, 1);
    chk("R9 fs from pin lo", frame_sync, 0);
    clk_pin_in = 1'b0; fs_pin_in = 1'b1; #1;
    chk("R9 clk from pin lo", bit_clk, 0);
    chk("R9 fs from pin hi", frame_sync, 1);
  endtask

  initial begin
    rst_n = 1'b0; div_rst_n = 1'b0; fs_rst_n = 1'b0;
    src_sel = 1'b0; div = '0; frame_mode = 1'b1; per = '0; wid = '0;
    xfer_load = 1'b0; clk_dir = 1'b1; fs_dir = 1'b1;
    clk_pin_in = 1'b0; fs_pin_in = 1'b0;
    t_reset();
    t_div(3);
    t_div(4);
    t_div(1);
    t_div(99);
    t_ext();
    t_divrst();
    t_periodic(3, 9, 2);
    t_periodic(1, 4, 0);
    t_load();
    t_same();
    t_restart();
    t_fsrst();
    t_pins();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule